// File: doc/BRIEF.md
# Extended Hamming SECDED Codec (8,4)

This block protects a 4-bit value with an extended Hamming code that corrects any one flipped bit and detects any two. Its encoder side is purely combinational. It takes a nibble and produces an 8-bit codeword, made of the four data bits followed by three position check bits and one overall parity bit held in the least significant bit.

The decoder side takes a received 8-bit word and computes a 4-bit syndrome. It flips the bit the syndrome points at when exactly one bit is wrong. When two bits are wrong it leaves the word untouched and raises a double-error flag. The decoder results can leave through one optional register stage (parameter `OUT_REG`), so the codec can sit on a timing-critical path without changing its function.

Nibble bit 3 is D1 and bit 0 is D4. Frame bits, from bit 7 down to bit 0, carry D1 D2 D3 D4 C1 C2 C4 C3.

Top module: `secded_codec`

## Requirements
- R1: `enc_frame_o[7:4]` equals `enc_data_i`. The check bits are `enc_frame_o[3]` = C1 = D1^D2^D4, `enc_frame_o[2]` = C2 = D1^D3^D4 and `enc_frame_o[1]` = C4 = D2^D3^D4.
- R2: `enc_frame_o[0]` (C3) makes the XOR of all eight encoder output bits equal 0.
- R3: `dec_syndrome_o` is {A1,A2,A3,A4}. A1 is the XOR of all eight received bits, A2 = f[6]^f[5]^f[4]^f[1], A3 = f[7]^f[5]^f[4]^f[2] and A4 = f[7]^f[6]^f[4]^f[3].
- R4: A received valid codeword gives syndrome 0000 and both flags low. The data and frame outputs equal the received bits.
- R5: A single flipped data bit is restored. The position code {A2,A3,A4} is 011 for D1, 101 for D2, 110 for D3 and 111 for D4. `dec_single_o` is high, `dec_double_o` is low, and `dec_frame_o` is the original codeword.
- R6: A single flipped C1, C2 or C4 (position codes 001, 010 and 100) raises `dec_single_o` and restores that check bit. `dec_data_o` is the original data.
- R7: A single flipped C3 gives A1=1 with position code 000. `dec_single_o` is high and the frame is restored.
- R8: A1=0 with a nonzero position code raises `dec_double_o` with `dec_single_o` low. The data and frame outputs are the received bits, uncorrected.
- R9: With `OUT_REG`=1 (the default), the decoder outputs show the result for the word present at the previous rising clock edge. While `rst_ni` is low they are all zero. The encoder stays combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional decoder output stage |
| rst_ni | input | 1 | Asynchronous active-low reset of the output stage |
| enc_data_i | input | 4 | Nibble to encode (bit 3 = D1) |
| enc_frame_o | output | 8 | Encoded codeword |
| dec_frame_i | input | 8 | Received word to decode |
| dec_data_o | output | 4 | Corrected (or passed-through) data |
| dec_frame_o | output | 8 | Corrected (or passed-through) full word |
| dec_syndrome_o | output | 4 | Syndrome {A1,A2,A3,A4} |
| dec_single_o | output | 1 | A single-bit error was corrected |
| dec_double_o | output | 1 | An uncorrectable double-bit error was found |

## Verification
A wrong entry in the map from position code to bit flips the wrong bit. That shows one output cycle later as corrupted data, or as a repaired word that is still not a codeword. A flag mixup shows as a double error reported as corrected, or the reverse. Exhaustive decoding of all 256 received words is compared against a nearest-codeword search. It exposes any such fault on the first affected word, and a missing or extra output stage shows in a sample taken between a new input and the next clock edge.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 4;
  localparam int CHK_W  = 3;
  localparam int FRM_W  = DATA_W + CHK_W + 1;
  localparam int SYN_W  = CHK_W + 1;

  typedef logic [FRM_W-1:0]  frame_t;
  typedef logic [DATA_W-1:0] nibble_t;
  typedef logic [SYN_W-1:0]  synd_t;

  // position check bits {C1,C2,C4}; d[3]=D1 .. d[0]=D4
  function automatic logic [CHK_W-1:0] pos_checks(nibble_t d);
    logic c1, c2, c4;
    c1 = d[3] ^ d[2] ^ d[0];
    c2 = d[3] ^ d[1] ^ d[0];
    c4 = d[2] ^ d[1] ^ d[0];
    return {c1, c2, c4};
  endfunction

  // full codeword with the even overall parity bit in bit 0
  function automatic frame_t build_frame(nibble_t d);
    frame_t f;
    f    = {d, pos_checks(d), 1'b0};
    f[0] = ^f[FRM_W-1:1];
    return f;
  endfunction

  // syndrome {A1,A2,A3,A4}
  function automatic synd_t calc_syndrome(frame_t f);
    logic a1, a2, a3, a4;
    a1 = ^f;
    a2 = f[6] ^ f[5] ^ f[4] ^ f[1];
    a3 = f[7] ^ f[5] ^ f[4] ^ f[2];
    a4 = f[7] ^ f[6] ^ f[4] ^ f[3];
    return {a1, a2, a3, a4};
  endfunction

  // position code produced by a lone error in frame bit idx
  function automatic logic [CHK_W-1:0] bit_signature(int idx);
    logic [CHK_W-1:0] s;
    case (idx)
      7:       s = 3'b011;
      6:       s = 3'b101;
      5:       s = 3'b110;
      4:       s = 3'b111;
      3:       s = 3'b001;
      2:       s = 3'b010;
      1:       s = 3'b100;
      default: s = 3'b000;
    endcase
    return s;
  endfunction

  // one-hot mask of the frame bit a position code points at
  function automatic frame_t flip_mask(logic [CHK_W-1:0] pos);
    frame_t m;
    m = '0;
    for (int i = 0; i < FRM_W; i++) begin
      m[i] = (bit_signature(i) == pos);
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  nibble_t data_i,
  output frame_t  frame_o
);

  assign frame_o = build_frame(data_i);

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
(
  input  frame_t frame_i,
  output synd_t  synd_o,
  output logic   single_o,
  output logic   double_o
);

  synd_t syn;
  logic  pos_nz;

  always_comb begin
    syn      = calc_syndrome(frame_i);
    pos_nz   = |syn[CHK_W-1:0];
    single_o = syn[SYN_W-1];
    double_o = !syn[SYN_W-1] && pos_nz;
    synd_o   = syn;
  end

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
  import secded_pkg::*;
(
  input  frame_t frame_i,
  input  synd_t  synd_i,
  input  logic   single_i,
  output frame_t frame_o
);

  frame_t mask;

  always_comb begin
    mask    = single_i ? flip_mask(synd_i[CHK_W-1:0]) : '0;
    frame_o = frame_i ^ mask;
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] enc_data_i,
  output logic [7:0] enc_frame_o,
  input  logic [7:0] dec_frame_i,
  output logic [3:0] dec_data_o,
  output logic [7:0] dec_frame_o,
  output logic [3:0] dec_syndrome_o,
  output logic       dec_single_o,
  output logic       dec_double_o
);

  synd_t  w_synd;
  logic   w_single;
  logic   w_double;
  frame_t w_fixed;

  secded_encoder u_enc (
    .data_i  (enc_data_i),
    .frame_o (enc_frame_o)
  );

  secded_syndrome u_syn (
    .frame_i  (dec_frame_i),
    .synd_o   (w_synd),
    .single_o (w_single),
    .double_o (w_double)
  );

  secded_corrector u_cor (
    .frame_i  (dec_frame_i),
    .synd_i   (w_synd),
    .single_i (w_single),
    .frame_o  (w_fixed)
  );

  generate
    if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          dec_frame_o    <= '0;
          dec_syndrome_o <= '0;
          dec_single_o   <= 1'b0;
          dec_double_o   <= 1'b0;
        end else begin
          dec_frame_o    <= w_fixed;
          dec_syndrome_o <= w_synd;
          dec_single_o   <= w_single;
          dec_double_o   <= w_double;
        end
      end
    end else begin : g_out_comb
      assign dec_frame_o    = w_fixed;
      assign dec_syndrome_o = w_synd;
      assign dec_single_o   = w_single;
      assign dec_double_o   = w_double;
    end
  endgenerate

  assign dec_data_o = dec_frame_o[FRM_W-1 -: DATA_W];

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] enc_data_i,
  input logic [7:0] enc_frame_o,
  input logic [7:0] dec_frame_i,
  input logic [3:0] c_synd,
  input logic       c_single,
  input logic       c_double,
  input logic [7:0] c_fixed,
  input logic [3:0] dec_data_o,
  input logic [7:0] dec_frame_o,
  input logic       dec_single_o,
  input logic       dec_double_o
);

  p_enc_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_frame_o[7:4] == enc_data_i);

  p_enc_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^enc_frame_o) == 1'b0);

  p_clean_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_synd == 4'b0000) |-> (!c_single && !c_double && c_fixed == dec_frame_i));

  p_single_fix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_single |-> ((^c_fixed) == 1'b0 && $countones(c_fixed ^ dec_frame_i) == 1));

  p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_single && c_double));

  p_double_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_double |-> (c_fixed == dec_frame_i));

  generate
    if (OUT_REG) begin : g_stage_chk
      p_out_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (dec_frame_o == $past(c_fixed) && dec_single_o == $past(c_single)
                  && dec_double_o == $past(c_double) && dec_data_o == $past(c_fixed[7:4])));
    end
  endgenerate

endmodule

bind secded_codec secded_codec_chk #(.OUT_REG(OUT_REG)) u_secded_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enc_data_i   (enc_data_i),
  .enc_frame_o  (enc_frame_o),
  .dec_frame_i  (dec_frame_i),
  .c_synd       (w_synd),
  .c_single     (w_single),
  .c_double     (w_double),
  .c_fixed      (w_fixed),
  .dec_data_o   (dec_data_o),
  .dec_frame_o  (dec_frame_o),
  .dec_single_o (dec_single_o),
  .dec_double_o (dec_double_o)
);

// File: tb/test_secded_codec.sv
module test_secded_codec;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] enc_data_i;
  logic [7:0] enc_frame_o;
  logic [7:0] dec_frame_i;
  logic [3:0] dec_data_o;
  logic [7:0] dec_frame_o;
  logic [3:0] dec_syndrome_o;
  logic       dec_single_o;
  logic       dec_double_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  secded_codec #(.OUT_REG(1'b1)) i_secded_codec (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .enc_data_i     (enc_data_i),
    .enc_frame_o    (enc_frame_o),
    .dec_frame_i    (dec_frame_i),
    .dec_data_o     (dec_data_o),
    .dec_frame_o    (dec_frame_o),
    .dec_syndrome_o (dec_syndrome_o),
    .dec_single_o   (dec_single_o),
    .dec_double_o   (dec_double_o)
  );

  // generator rows: weight-4 codewords of D1..D4 (R1, R2)
  function automatic logic [7:0] ref_encode(logic [3:0] d);
    logic [7:0] f;
    f = 8'h00;
    if (d[3]) f ^= 8'h8D;
    if (d[2]) f ^= 8'h4B;
    if (d[1]) f ^= 8'h27;
    if (d[0]) f ^= 8'h1E;
    return f;
  endfunction

  // syndrome as listed in R3
  function automatic logic [3:0] ref_syndrome(logic [7:0] f);
    return {^f, f[6]^f[5]^f[4]^f[1], f[7]^f[5]^f[4]^f[2], f[7]^f[6]^f[4]^f[3]};
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive one encoder nibble and one received word, check both sides
  task automatic run_vec(logic [3:0] d, logic [7:0] f);
    logic [7:0] best, diff;
    int         mind;
    string      tag;
    logic [7:0] exp_frame;
    logic       exp_single, exp_double;
    @(negedge clk_i);
    enc_data_i  = d;
    dec_frame_i = f;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1", "encoder frame", enc_frame_o, ref_encode(d));
    check("R2", "encoder parity", {7'd0, ^enc_frame_o}, 8'h00);
    // nearest codeword by exhaustive search
    mind = 9;
    best = 8'h00;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] cw;
      cw = ref_encode(k[3:0]);
      if ($countones(cw ^ f) < mind) begin
        mind = $countones(cw ^ f);
        best = cw;
      end
    end
    diff = best ^ f;
    if (mind == 0) begin
      tag = "R4"; exp_frame = f; exp_single = 1'b0; exp_double = 1'b0;
    end else if (mind == 1) begin
      exp_frame = best; exp_single = 1'b1; exp_double = 1'b0;
      if (diff[7:4] != 4'h0)  tag = "R5";
      else if (diff[0])       tag = "R7";
      else                    tag = "R6";
    end else begin
      tag = "R8"; exp_frame = f; exp_single = 1'b0; exp_double = 1'b1;
    end
    check("R3", "syndrome", {4'h0, dec_syndrome_o}, {4'h0, ref_syndrome(f)});
    check(tag, "data", {4'h0, dec_data_o}, {4'h0, exp_frame[7:4]});
    check(tag, "frame", dec_frame_o, exp_frame);
    check(tag, "single flag", {7'd0, dec_single_o}, {7'd0, exp_single});
    check(tag, "double flag", {7'd0, dec_double_o}, {7'd0, exp_double});
  endtask

  // R9: a new word must not reach the outputs before the next rising edge
  task automatic latency_probe(logic [7:0] next_f);
    logic [7:0] held;
    held = dec_frame_o;
    @(negedge clk_i);
    dec_frame_i = next_f;
    #1;
    check("R9", "output held before edge", dec_frame_o, held);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val    = $urandom(32'h5EC0_0D8);
    rst_ni      = 1'b0;
    enc_data_i  = 4'h0;
    dec_frame_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    check("R9", "reset frame", dec_frame_o, 8'h00);
    check("R9", "reset data", {4'h0, dec_data_o}, 8'h00);
    check("R9", "reset syndrome", {4'h0, dec_syndrome_o}, 8'h00);
    check("R9", "reset flags", {6'd0, dec_single_o, dec_double_o}, 8'h00);
    rst_ni = 1'b1;

    // directed: each single flip of two codewords, including C3 (R5, R6, R7)
    for (int b = 0; b < 8; b++) begin
      run_vec(4'h0, ref_encode(4'h0) ^ (8'h01 << b));
      run_vec(4'hF, ref_encode(4'hA) ^ (8'h01 << b));
    end
    // directed: double flips (R8)
    run_vec(4'h5, ref_encode(4'h5) ^ 8'h81);
    run_vec(4'h9, ref_encode(4'hF) ^ 8'h06);
    run_vec(4'h3, ref_encode(4'h6) ^ 8'h30);
    latency_probe(ref_encode(4'h7));
    run_vec(4'h7, ref_encode(4'h7));

    // exhaustive received words
    for (int w = 0; w < 256; w++) begin
      run_vec(w[7:4], w[7:0]);
    end

    // random codewords with zero, one or two flipped bits
    for (int n = 0; n < 400; n++) begin
      logic [3:0] d;
      logic [7:0] f;
      int unsigned nerr, p0, p1;
      d    = 4'($urandom);
      f    = ref_encode(d);
      nerr = $urandom % 3;
      p0   = $urandom % 8;
      p1   = (p0 + 1 + ($urandom % 7)) % 8;
      if (nerr >= 1) f ^= (8'h01 << p0);
      if (nerr == 2) f ^= (8'h01 << p1);
      if (n % 50 == 0) latency_probe(f ^ 8'h10);
      run_vec(d, f);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule